// File: doc/BRIEF.md
# USB Low-Speed Packet Serializer

This block sends one short USB low-speed packet on the D+/D- pair. Each line symbol lasts a fixed number of system clocks, ten by default. A single start strobe launches a packet. The packet length is given as a total byte count, and that count includes the sync byte. The block first presets the lines to the idle (J) level with the output enable still low. It then enables the drivers and holds J for one bit time. After that it sends the sync byte and the payload, least significant bit first. The bits are NRZI coded, and a stuffed toggle is inserted after every run of six 1 bits. The packet closes with an end-of-packet sequence, after which the drivers are released.

Payload bytes are pulled one at a time. The block raises a one-cycle request and samples the byte input on that same cycle. The first payload byte is requested right after start is accepted. Each later byte is requested when the byte before it moves into the shift register, which leaves a whole byte time to supply it.

At release, a completion pulse fires. When the packet was longer than a bare two-byte handshake, a second pulse fires alongside it so that a device address held pending elsewhere can take effect. A receive-start flag, set by an external edge indication, is wiped at release, because the block's own line activity raises that indication during sending.

Top module: `ls_pkt_tx`

## Requirements
- R1: A start strobe is taken only while the block is idle and `byte_count_i` lies in 2..12. Any other start leaves `busy_o`, `oe_o` and `byte_req_o` low, and a start during a packet leaves that packet's waveform unchanged.
- R2: In the cycle after acceptance, the lines show J (`dp_o`=0, `dm_o`=1) with `oe_o` low. From the next cycle, `oe_o` is high and J is held for one bit time.
- R3: The sync byte 0x80 goes first, then the `byte_count_i`-1 payload bytes, each least significant bit first. Every symbol lasts CLKS_PER_BIT cycles. Exactly `byte_count_i`-1 request pulses are made per packet, and `byte_data_i` is sampled in each cycle where `byte_req_o` is high.
- R4: NRZI coding is used: a 0 bit toggles the line state and a 1 bit keeps it. J is `dp_o`=0/`dm_o`=1 and K is `dp_o`=1/`dm_o`=0. The state before the first symbol is J.
- R5: After six consecutive 1 bits, one extra toggle symbol is sent. The run count starts at zero for each packet and continues across byte boundaries. It also applies after the final data bit.
- R6: The end of packet is two bit times of SE0 (both lines low), then one bit time of J. After that `oe_o` drops and both lines are driven low.
- R7: `busy_o` is high from the cycle after acceptance until release. `done_o` is a single-cycle pulse in the release cycle.
- R8: `addr_commit_o` pulses together with `done_o` only when `byte_count_i` was greater than 2.
- R9: `rx_flag_o` is set one cycle after `rx_edge_i` and cleared by `rx_clr_i`. It is forced low in the release cycle of every packet.
- R10: `dp_o` and `dm_o` are never both high while `oe_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a packet (taken when idle) |
| byte_count_i | input | CNT_W | Total bytes including sync, 2..MAX_BYTES |
| byte_data_i | input | 8 | Payload byte, sampled while byte_req_o is high |
| byte_req_o | output | 1 | One-cycle request for the next payload byte |
| rx_edge_i | input | 1 | Receive-start edge indication |
| rx_clr_i | input | 1 | Clears the receive-start flag |
| dp_o | output | 1 | D+ output level |
| dm_o | output | 1 | D- output level |
| oe_o | output | 1 | Output enable for both lines |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | Pulse at release |
| addr_commit_o | output | 1 | Pulse at release of a data packet |
| rx_flag_o | output | 1 | Receive-start flag |

## Verification
The hardest situations to reach are stuffing that straddles a byte boundary and a stuffed toggle that must follow the very last data bit. Both depend on the run of 1 bits landing exactly right relative to the sync byte's final 1 bit and the packet's end. Directed payloads reach them: 0x1F right after sync, 0xFF bytes back to back, and a packet ending in 0xFC. Random payloads and lengths come on top, and every one of them is compared cycle by cycle against a waveform the bench builds from the coding rules. One long packet also carries a late start strobe and a receive edge, to show that the start is ignored and that the flag is wiped.

// File: rtl/ls_tx_pkg.sv
package ls_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LEAD,
    ST_SEND,
    ST_EOP
  } tx_state_t;
endpackage

// File: rtl/ls_tx_bit_timer.sv
module ls_tx_bit_timer #(
  parameter int CLKS_PER_BIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic wrap_o
);
  localparam int TW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [TW-1:0] LAST = TW'(CLKS_PER_BIT - 1);

  logic [TW-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst || !run_i) tick <= '0;
    else if (tick == LAST) tick <= '0;
    else tick <= tick + 1'b1;
  end

  assign wrap_o = run_i && (tick == LAST);

  // R3: symbol period counter stays inside one bit time
  a_r3_tick_range: assert property (@(posedge clk) disable iff (rst)
    tick <= LAST);
endmodule

// File: rtl/ls_tx_byte_feed.sv
module ls_tx_byte_feed #(
  parameter int          CNT_W     = 4,
  parameter logic [7:0]  SYNC_BYTE = 8'h80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             take_i,
  input  logic [7:0]       data_i,
  output logic             req_o,
  output logic             bit_o,
  output logic             more_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [7:0]       sh;
  logic [7:0]       hold;
  logic [2:0]       bidx;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      hold   <= '0;
      bidx   <= '0;
      left   <= '0;
      more_o <= 1'b0;
      req_o  <= 1'b0;
    end else begin
      req_o <= 1'b0;
      if (req_o) hold <= data_i;
      if (load_i) begin
        sh     <= SYNC_BYTE;
        bidx   <= '0;
        left   <= count_i - ONE;
        more_o <= 1'b1;
        req_o  <= 1'b1;
      end else if (take_i) begin
        if (bidx == 3'd7) begin
          if (left != '0) begin
            sh    <= hold;
            left  <= left - ONE;
            bidx  <= '0;
            req_o <= (left > ONE);
          end else begin
            more_o <= 1'b0;
          end
        end else begin
          sh   <= {1'b0, sh[7:1]};
          bidx <= bidx + 3'd1;
        end
      end
    end
  end

  assign bit_o = sh[0];

  // R3: the encoder consumes a bit only while bits remain
  a_r3_take_needs_bits: assert property (@(posedge clk) disable iff (rst)
    take_i |-> more_o);
  // R3: a fetch request never coincides with a byte hand-over
  a_r3_req_not_on_take: assert property (@(posedge clk) disable iff (rst)
    req_o |-> !take_i);
endmodule

// File: rtl/ls_tx_nrzi_enc.sv
module ls_tx_nrzi_enc #(
  parameter int RUN_MAX = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic init_i,
  input  logic adv_i,
  input  logic bit_i,
  input  logic more_i,
  output logic take_o,
  output logic fin_o,
  output logic nxt_j_o
);
  localparam int OW = $clog2(RUN_MAX + 1);
  localparam logic [OW-1:0] RUN_LIM = OW'(RUN_MAX);

  logic [OW-1:0] ones;
  logic          line_j;
  logic          stuff;

  assign stuff  = (ones == RUN_LIM);
  assign take_o = adv_i && !stuff && more_i;
  assign fin_o  = !stuff && !more_i;

  always_comb begin
    if (stuff) nxt_j_o = !line_j;
    else if (more_i && !bit_i) nxt_j_o = !line_j;
    else nxt_j_o = line_j;
  end

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      ones   <= '0;
      line_j <= 1'b1;
    end else if (adv_i) begin
      line_j <= nxt_j_o;
      if (stuff) ones <= '0;
      else if (more_i) ones <= bit_i ? ones + 1'b1 : '0;
    end
  end

  // R5: the run of ones never passes the stuffing limit
  a_r5_run_bound: assert property (@(posedge clk) disable iff (rst)
    ones <= RUN_LIM);
endmodule

// File: rtl/ls_pkt_tx.sv
module ls_pkt_tx
  import ls_tx_pkg::*;
#(
  parameter int         CLKS_PER_BIT = 10,
  parameter int         MIN_BYTES    = 2,
  parameter int         MAX_BYTES    = 12,
  parameter int         HS_BYTES     = 2,
  parameter int         SE0_BITS     = 2,
  parameter int         RUN_MAX      = 6,
  parameter logic [7:0] SYNC_BYTE    = 8'h80,
  parameter int         CNT_W        = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic [7:0]       byte_data_i,
  output logic             byte_req_o,
  input  logic             rx_edge_i,
  input  logic             rx_clr_i,
  output logic             dp_o,
  output logic             dm_o,
  output logic             oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             addr_commit_o,
  output logic             rx_flag_o
);
  localparam int EW = $clog2(SE0_BITS + 1);
  localparam logic [EW-1:0] EOP_LAST = EW'(SE0_BITS);
  localparam logic [EW-1:0] J_AT     = EW'(SE0_BITS - 1);

  tx_state_t     state;
  logic [EW-1:0] eop_cnt;
  logic          is_data;
  logic          accept, wrap, tmr_run, sym_adv, release_now;
  logic          take, fin, nxt_j, cur_bit, more;

  assign accept = (state == ST_IDLE) && start_i &&
                  (byte_count_i >= CNT_W'(MIN_BYTES)) &&
                  (byte_count_i <= CNT_W'(MAX_BYTES));
  assign tmr_run = (state == ST_LEAD) || (state == ST_SEND) || (state == ST_EOP);
  assign sym_adv = wrap && ((state == ST_LEAD) || (state == ST_SEND));
  assign release_now = (state == ST_EOP) && wrap && (eop_cnt == EOP_LAST);

  ls_tx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) timer_i (
    .clk(clk), .rst(rst), .run_i(tmr_run), .wrap_o(wrap)
  );

  ls_tx_byte_feed #(.CNT_W(CNT_W), .SYNC_BYTE(SYNC_BYTE)) feed_i (
    .clk(clk), .rst(rst), .load_i(accept), .count_i(byte_count_i),
    .take_i(take), .data_i(byte_data_i), .req_o(byte_req_o),
    .bit_o(cur_bit), .more_o(more)
  );

  ls_tx_nrzi_enc #(.RUN_MAX(RUN_MAX)) enc_i (
    .clk(clk), .rst(rst), .init_i(accept), .adv_i(sym_adv),
    .bit_i(cur_bit), .more_i(more), .take_o(take), .fin_o(fin),
    .nxt_j_o(nxt_j)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      dp_o          <= 1'b0;
      dm_o          <= 1'b0;
      oe_o          <= 1'b0;
      busy_o        <= 1'b0;
      done_o        <= 1'b0;
      addr_commit_o <= 1'b0;
      is_data       <= 1'b0;
      eop_cnt       <= '0;
    end else begin
      done_o        <= 1'b0;
      addr_commit_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_PRE;
          dp_o    <= 1'b0;
          dm_o    <= 1'b1;
          busy_o  <= 1'b1;
          is_data <= (byte_count_i > CNT_W'(HS_BYTES));
        end
        ST_PRE: begin
          state <= ST_LEAD;
          oe_o  <= 1'b1;
        end
        ST_LEAD: if (wrap) begin
          state <= ST_SEND;
          dp_o  <= !nxt_j;
          dm_o  <= nxt_j;
        end
        ST_SEND: if (wrap) begin
          if (fin) begin
            state   <= ST_EOP;
            eop_cnt <= '0;
            dp_o    <= 1'b0;
            dm_o    <= 1'b0;
          end else begin
            dp_o <= !nxt_j;
            dm_o <= nxt_j;
          end
        end
        ST_EOP: if (wrap) begin
          if (eop_cnt == EOP_LAST) begin
            state         <= ST_IDLE;
            oe_o          <= 1'b0;
            dp_o          <= 1'b0;
            dm_o          <= 1'b0;
            busy_o        <= 1'b0;
            done_o        <= 1'b1;
            addr_commit_o <= is_data;
          end else begin
            eop_cnt <= eop_cnt + 1'b1;
            if (eop_cnt == J_AT) begin
              dp_o <= 1'b0;
              dm_o <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || release_now || rx_clr_i) rx_flag_o <= 1'b0;
    else if (rx_edge_i) rx_flag_o <= 1'b1;
  end

  // R2: drivers switch on only onto a J level that was already preset
  a_r2_take_bus_in_j: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_o) |-> (!dp_o && dm_o && !$past(dp_o) && $past(dm_o)));
  // R10: no SE1 while driving
  a_r10_no_se1: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> !(dp_o && dm_o));
  // R6: release leaves both lines low and follows a J symbol
  a_r6_release_low: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_o) |-> (!dp_o && !dm_o && $past(dm_o) && !$past(dp_o)));
  // R7: completion is a one-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R7: drivers are enabled only during a packet
  a_r7_oe_in_busy: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> busy_o);
  // R8: address commit only with completion
  a_r8_commit_with_done: assert property (@(posedge clk) disable iff (rst)
    addr_commit_o |-> done_o);
  // R9: flag is low right after a packet is released
  a_r9_flag_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> !rx_flag_o);
endmodule

// File: tb/ls_pkt_tx_tb_top.sv
module ls_pkt_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] count = 4'd0;
  logic [7:0] byte_data;
  logic       byte_req;
  logic       rx_edge = 1'b0;
  logic       rx_clr = 1'b0;
  logic       dp, dm, oe, busy, done, commit, rx_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int req_cnt = 0;
  int base = 0;
  logic [7:0] pay [16];

  always #5 clk = ~clk;

  always @(posedge clk) if (byte_req) req_cnt <= req_cnt + 1;
  assign byte_data = pay[(req_cnt - base) & 15];

  ls_pkt_tx dut_i (
    .clk(clk), .rst(rst), .start_i(start), .byte_count_i(count),
    .byte_data_i(byte_data), .byte_req_o(byte_req),
    .rx_edge_i(rx_edge), .rx_clr_i(rx_clr),
    .dp_o(dp), .dm_o(dm), .oe_o(oe), .busy_o(busy), .done_o(done),
    .addr_commit_o(commit), .rx_flag_o(rx_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_at(input int c, input int ns,
                                        input logic sym [0:255]);
    logic j;
    if (c == 0) return 5'b00110;
    if (c <= 10) return 5'b10110;
    if (c <= 10 + 10 * ns) begin
      j = sym[(c - 11) / 10];
      return {1'b1, !j, j, 1'b1, 1'b0};
    end
    if (c <= 30 + 10 * ns) return 5'b10010;
    if (c <= 40 + 10 * ns) return 5'b10110;
    if (c == 41 + 10 * ns) return 5'b00001;
    return 5'b00000;
  endfunction

  // drives one packet of n bytes (pay[0..n-2] payload) and compares every cycle
  task automatic run_pkt(input int n, input bit mid);
    logic sym [0:255];
    int ns = 0;
    logic lj = 1'b1;
    int ones = 0;
    int last;
    int bad_at = -1;
    int bad_got = 0;
    int bad_exp = 0;
    logic [7:0] v;
    logic [4:0] got, ex;
    for (int b = 0; b < n; b++) begin
      v = (b == 0) ? 8'h80 : pay[b - 1];
      for (int i = 0; i < 8; i++) begin
        if (!v[i]) begin lj = ~lj; ones = 0; end
        else ones++;
        sym[ns] = lj; ns++;
        if (ones == 6) begin lj = ~lj; sym[ns] = lj; ns++; ones = 0; end
      end
    end
    last = 41 + 10 * ns;
    @(negedge clk);
    base = req_cnt;
    count = 4'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= last + 1; c++) begin
      ex  = exp_at(c, ns, sym);
      got = {oe, dp, dm, busy, done};
      if (got != ex && bad_at < 0) begin
        bad_at = c; bad_got = int'(got); bad_exp = int'(ex);
      end
      if (c == last) check(commit == (n > 2), "R8", "address commit", int'(commit), int'(n > 2));
      if (mid && c == last) check(rx_flag == 1'b0, "R9", "flag wiped at release", int'(rx_flag), 0);
      if (mid && c == 51) begin
        check(rx_flag == 1'b1, "R9", "flag set during send", int'(rx_flag), 1);
        start = 1'b0; rx_edge = 1'b0;
      end
      if (mid && c == 50) begin
        start = 1'b1; count = 4'd3; rx_edge = 1'b1;
      end
      if (c <= last) @(negedge clk);
    end
    if (bad_at >= 0) $display("  packet n=%0d first mismatch at cycle %0d", n, bad_at);
    check(bad_at < 0, "R2 R3 R4 R5 R6 R7", "{oe,dp,dm,busy,done} waveform", bad_got, bad_exp);
    check(req_cnt - base == n - 1, "R3", "byte request count", req_cnt - base, n - 1);
  endtask

  task automatic try_bad(input int n);
    bit ok = 1'b1;
    @(negedge clk);
    count = 4'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (busy || oe || byte_req) ok = 1'b0;
      @(negedge clk);
    end
    check(ok, "R1", $sformatf("start with count %0d ignored", n), int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) pay[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({oe, dp, dm, busy, done, commit, byte_req, rx_flag} == 8'h00, "R7",
          "reset state", int'({oe, dp, dm, busy, done, commit, byte_req, rx_flag}), 0);

    // R9: flag set and clear while idle
    rx_edge = 1'b1; @(negedge clk); rx_edge = 1'b0;
    check(rx_flag == 1'b1, "R9", "idle flag set", int'(rx_flag), 1);
    rx_clr = 1'b1; @(negedge clk); rx_clr = 1'b0;
    check(rx_flag == 1'b0, "R9", "idle flag clear", int'(rx_flag), 0);

    // R1: out-of-range counts
    try_bad(0);
    try_bad(1);
    try_bad(13);

    // R8: handshake, no commit
    pay[0] = 8'hD2;
    run_pkt(2, 1'b0);
    // R5: run crossing the sync boundary
    pay[0] = 8'h1F;
    run_pkt(2, 1'b0);
    // R5: long runs across payload bytes
    pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'hFF;
    run_pkt(4, 1'b0);
    // R5: stuffed toggle after the final data bit
    pay[0] = 8'h00; pay[1] = 8'hFC;
    run_pkt(3, 1'b0);
    // R1/R9: longest packet with a late start and a receive edge
    for (int i = 0; i < 11; i++) pay[i] = 8'($urandom());
    run_pkt(12, 1'b1);
    // random lengths and data
    for (int k = 0; k < 12; k++) begin
      n = 2 + int'($urandom_range(10));
      for (int i = 0; i < 11; i++) pay[i] = ($urandom_range(3) == 0) ? 8'hFF : 8'($urandom());
      run_pkt(n, 1'b0);
    end
    try_bad(15);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule